// File: doc/BRIEF.md
# Serial Polynomial Signature Analyzer

This block compacts a serial response stream into a short signature. It treats the incoming bits as the coefficients of a polynomial, highest degree first, and divides that polynomial over GF(2) by the fixed divisor P(x) = 1 + x^2 + x^4 + x^5. The division uses a five-stage shift register with the feedback XORed in between stages. Once the whole stream has been shifted in, the register holds the remainder of the division, and that remainder is the signature. The bit that leaves the top stage on each shift makes up the quotient stream.

A test controller clears the analyzer, then sets the enable and drives one response bit per clock. A bit counter raises a ready flag once a parameterised number of bits has been taken in. The controller then reads the five-bit signature. With five flip-flops, a faulty stream has a chance of about 1/32 of leaving the same signature as the good stream.

Top module: `sig_analyzer`

## Requirements
- R1: When `clr` is high at a rising edge, the next state has `signature` = 0 and `ready` = 0. This holds whatever `en` and `din` are, so clear takes priority over enable.
- R2: On a rising edge with `clr` low and `en` high, the new state is computed from the old state with f = old `signature[4]`: bit 0 takes `din` XOR f, bit 2 takes old bit 1 XOR f, bit 4 takes old bit 3 XOR f, bit 1 takes old bit 0, and bit 3 takes old bit 2.
- R3: On a rising edge with `clr` and `en` both low, `signature` and `ready` keep their values and the bit count does not advance, whatever `din` is.
- R4: `quo_bit` shows the current `signature[4]`, which is the quotient bit that leaves on the next enabled edge. Collect `quo_bit` just before each enabled edge of a stream that starts from a cleared register, oldest bit as the highest degree. The result is the quotient of the stream polynomial divided by P(x).
- R5: Clear the register and feed the stream 1,1,1,1,0,1,0,1 in time order, which is 1+x^2+x^4+x^5+x^6+x^7 with the highest degree first. `signature` then reads 5'b10100 (x^2 + x^4; bit i is the coefficient of x^i). The collected quotient is 1 + x^2.
- R6: `ready` goes high on the edge that takes in enabled bit number STREAM_LEN (default 8) after a clear. It is low before that edge and stays high until the next clear.
- R7: For any stream of up to 64 bits fed from a cleared register, the stream polynomial equals quotient × P(x) + signature over GF(2), and `signature` equals the stream polynomial modulo P(x).
- R8: Flip any single bit of a stream and the resulting signature differs from the signature of the original stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Synchronous active-high clear of the register and the bit count |
| en | input | 1 | Take in one stream bit on this edge |
| din | input | 1 | Serial stream bit, highest-degree coefficient first |
| signature | output | 5 | Remainder register; bit i is the coefficient of x^i |
| quo_bit | output | 1 | Quotient bit that leaves on the next enabled edge |
| ready | output | 1 | High once STREAM_LEN bits have been taken in since the last clear |

## Verification
The bench focuses on the known eight-bit stream. A register that has its taps in the wrong places, or that uses the new top bit as feedback instead of the old one, gives a remainder other than x^2+x^4 and a quotient other than 1+x^2. Random streams of assorted lengths are checked against a long-division model in the bench and against the relation stream = Q·P + R. A wrong stage order or a swapped bit order in the signature breaks both checks. Enable gaps with a toggling input check that an idle edge neither shifts the register nor advances the count, since either fault would move the ready edge or alter the signature. A clear issued together with enable checks the priority. Single-bit flips check that one error always changes the signature.

// File: rtl/sig_pkg.sv
package sig_pkg;
    // Number of remainder stages, equal to the degree of the divisor.
    localparam int SA_WIDTH = 5;
    // Divisor coefficients x^0..x^4; the x^5 term is the feedback itself.
    localparam logic [SA_WIDTH-1:0] SA_TAPS = 5'b10101;

    typedef logic [SA_WIDTH-1:0] sig_t;

    // Update controls shared by every stage cell.
    typedef struct packed {
        logic clear;
        logic shift;
        logic feedback;
    } cell_ctl_t;

    function automatic cell_ctl_t make_ctl(input logic clr, input logic en,
                                           input logic fb);
        cell_ctl_t c;
        c.clear    = clr;
        c.shift    = en & ~clr;
        c.feedback = fb;
        return c;
    endfunction
endpackage

// File: rtl/sa_cell.sv
module sa_cell import sig_pkg::*; #(
    parameter bit TAP = 1'b0
) (
    input  logic      clk,
    input  cell_ctl_t ctl,
    input  logic      d_in,
    output logic      q
);
    logic next_bit;

    generate
        if (TAP) begin : g_tap
            assign next_bit = d_in ^ ctl.feedback;
        end else begin : g_plain
            assign next_bit = d_in;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (ctl.clear) begin
            q <= 1'b0;
        end else if (ctl.shift) begin
            q <= next_bit;
        end
    end
endmodule

// File: rtl/sa_bitcount.sv
module sa_bitcount #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic clr,
    input  logic en,
    output logic done
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIMIT_C = CW'(LIMIT);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (clr) begin
            cnt <= '0;
        end else if (en && (cnt != LIMIT_C)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = (cnt == LIMIT_C);
endmodule

// File: rtl/sig_analyzer.sv
module sig_analyzer import sig_pkg::*; #(
    parameter int STREAM_LEN = 8
) (
    input  logic                clk,
    input  logic                clr,
    input  logic                en,
    input  logic                din,
    output logic [SA_WIDTH-1:0] signature,
    output logic                quo_bit,
    output logic                ready
);
    sig_t      stage_q;
    sig_t      chain_in;
    cell_ctl_t ctl;

    assign ctl = make_ctl(clr, en, stage_q[SA_WIDTH-1]);

    generate
        for (genvar g = 0; g < SA_WIDTH; g++) begin : g_stage
            if (g == 0) begin : g_head
                assign chain_in[g] = din;
            end else begin : g_link
                assign chain_in[g] = stage_q[g-1];
            end
            sa_cell #(.TAP(SA_TAPS[g])) u_cell (
                .clk  (clk),
                .ctl  (ctl),
                .d_in (chain_in[g]),
                .q    (stage_q[g])
            );
        end
    endgenerate

    sa_bitcount #(.LIMIT(STREAM_LEN)) u_count (
        .clk  (clk),
        .clr  (clr),
        .en   (en),
        .done (ready)
    );

    assign signature = stage_q;
    assign quo_bit   = stage_q[SA_WIDTH-1];
endmodule

// File: rtl/sa_checker.sv
module sa_checker #(
    parameter int STREAM_LEN = 8
) (
    input logic       clk,
    input logic       clr,
    input logic       en,
    input logic       din,
    input logic [4:0] signature,
    input logic       quo_bit,
    input logic       ready
);
    logic started = 1'b0;
    int   seen    = 0;

    always_ff @(posedge clk) begin
        if (clr) begin
            started <= 1'b1;
            seen    <= 0;
        end else if (en && seen < STREAM_LEN) begin
            seen <= seen + 1;
        end
    end

    // R1: a clear empties the register and drops ready, enable or not
    a_r1_clear: assert property (@(posedge clk)
        clr |=> (signature == 5'b0) && !ready);

    // R2: plain stages copy their neighbour on an enabled edge
    a_r2_plain: assert property (@(posedge clk) disable iff (clr || !started)
        en |=> (signature[1] == $past(signature[0])) &&
               (signature[3] == $past(signature[2])));

    // R2: with the top stage set, the input is inverted into stage 0
    a_r2_feedback: assert property (@(posedge clk) disable iff (clr || !started)
        (en && signature[4]) |=> (signature[0] != $past(din)));

    // R3: an idle edge keeps the register and the flag
    a_r3_hold: assert property (@(posedge clk) disable iff (clr || !started)
        !en |=> $stable(signature) && $stable(ready));

    // R4: the quotient bit is the one about to leave the top stage
    a_r4_quotient: assert property (@(posedge clk) disable iff (!started)
        quo_bit == signature[4]);

    // R6: ready follows the count of enabled bits since clear
    a_r6_ready_count: assert property (@(posedge clk) disable iff (clr || !started)
        ready == (seen >= STREAM_LEN));

    // R6: once up, ready stays up until a clear
    a_r6_sticky: assert property (@(posedge clk) disable iff (clr || !started)
        ready |=> ready);
endmodule

bind sig_analyzer sa_checker #(.STREAM_LEN(STREAM_LEN)) u_chk (
    .clk       (clk),
    .clr       (clr),
    .en        (en),
    .din       (din),
    .signature (signature),
    .quo_bit   (quo_bit),
    .ready     (ready)
);

// File: tb/sig_analyzer_bench.sv
module sig_analyzer_bench;
    localparam logic [63:0] PDIV = 64'h35;   // 1 + x^2 + x^4 + x^5

    logic       clk = 1'b0;
    logic       clr = 1'b0;
    logic       en  = 1'b0;
    logic       din = 1'b0;
    logic [4:0] signature;
    logic       quo_bit;
    logic       ready;

    int checks   = 0;
    int failures = 0;

    always #2 clk = ~clk;   // 250 MHz

    sig_analyzer #(.STREAM_LEN(8)) u_sig_analyzer (
        .clk       (clk),
        .clr       (clr),
        .en        (en),
        .din       (din),
        .signature (signature),
        .quo_bit   (quo_bit),
        .ready     (ready)
    );

    function automatic logic [63:0] pmod(input logic [63:0] g);
        for (int d = 63; d >= 5; d--) begin
            if (g[d]) g = g ^ (PDIV << (d - 5));
        end
        return g;
    endfunction

    function automatic logic [63:0] pdiv(input logic [63:0] g);
        logic [63:0] q = '0;
        for (int d = 63; d >= 5; d--) begin
            if (g[d]) begin
                g = g ^ (PDIV << (d - 5));
                q[d-5] = 1'b1;
            end
        end
        return q;
    endfunction

    function automatic logic [63:0] clmul(input logic [63:0] a, input logic [63:0] b);
        logic [63:0] r = '0;
        for (int i = 0; i < 64; i++) begin
            if (a[i]) r = r ^ (b << i);
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_clear();
        @(negedge clk);
        clr = 1'b1; en = 1'b0;
        @(negedge clk);
        clr = 1'b0;
    endtask

    // Feeds len bits, highest degree first, collecting quo_bit before each edge.
    task automatic feed(input logic [63:0] g, input int len, output logic [63:0] qobs);
        qobs = '0;
        for (int i = len - 1; i >= 0; i--) begin
            qobs = (qobs << 1) | 64'(quo_bit);
            en  = 1'b1;
            din = g[i];
            @(negedge clk);
        end
        en = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        failures++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [63:0] q, g, g2, sig_a;
        int len;
        void'($urandom(32'd20240611));

        // R1: clear state
        do_clear();
        check(signature == 5'b0, "R1 reset signature", 64'(signature), 0);
        check(ready == 1'b0, "R1 reset ready", 64'(ready), 0);

        // R5: directed stream 1,1,1,1,0,1,0,1
        feed(64'hF5, 8, q);
        check(signature == 5'b10100, "R5 remainder", 64'(signature), 64'h14);
        check(q == 64'h5, "R5 quotient", q, 64'h5);
        check(ready == 1'b1, "R6 ready after 8", 64'(ready), 1);

        // R3 and R6: gaps with toggling din, ready timing
        do_clear();
        feed(64'h7A, 7, q);
        sig_a = 64'(signature);
        for (int k = 0; k < 4; k++) begin
            din = k[0]; en = 1'b0;
            @(negedge clk);
        end
        check(64'(signature) == sig_a, "R3 hold signature", 64'(signature), sig_a);
        check(ready == 1'b0, "R6 not ready after 7", 64'(ready), 0);
        feed(64'h1, 1, q);
        check(ready == 1'b1, "R6 ready on 8th bit", 64'(ready), 1);
        check(64'(signature) == pmod(64'hF5), "R3 gaps leave stream intact",
              64'(signature), pmod(64'hF5));
        feed(64'h5, 3, q);
        check(ready == 1'b1, "R6 ready stays high", 64'(ready), 1);

        // R1: clear wins over enable
        @(negedge clk);
        clr = 1'b1; en = 1'b1; din = 1'b1;
        @(negedge clk);
        clr = 1'b0; en = 1'b0;
        check(signature == 5'b0, "R1 clear beats enable", 64'(signature), 0);
        check(ready == 1'b0, "R1 clear drops ready", 64'(ready), 0);

        // R2: single stepping from a known state through feedback
        feed(64'h1F, 5, q);
        check(signature == 5'b11111, "R2 fill", 64'(signature), 64'h1F);
        feed(64'h0, 1, q);
        check(signature == 5'b01011, "R2 feedback step", 64'(signature), 64'h0B);
        check(quo_bit == 1'b0, "R4 top bit after step", 64'(quo_bit), 0);

        // R4, R7, R8: random streams
        for (int n = 0; n < 24; n++) begin
            len = 6 + int'($urandom % 59);
            g = {$urandom, $urandom};
            if (len < 64) g = g & ((64'h1 << len) - 1);
            do_clear();
            feed(g, len, q);
            sig_a = 64'(signature);
            check(sig_a == pmod(g), "R7 remainder", sig_a, pmod(g));
            check(q == pdiv(g), "R4 quotient stream", q, pdiv(g));
            check((clmul(q, PDIV) ^ sig_a) == g, "R7 Q*P+R", clmul(q, PDIV) ^ sig_a, g);
            g2 = g ^ (64'h1 << ($urandom % len));
            do_clear();
            feed(g2, len, q);
            check(64'(signature) != sig_a, "R8 single flip changes signature",
                  64'(signature), sig_a);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule